// File: doc/BRIEF.md
# Debug System Bus Access Engine

This block lets a debugger reach system memory without halting a processor. A debug register file passes it the current address, the write data and a set of control flags. The flags are: read when the address is written, read when the data is read, advance the address, and the access size. The register file also passes one-cycle strobes that mark a write to the address register, a write to the data register and a read of the data register. Each strobe can start exactly one single-beat transaction on a request/grant bus master port.

The engine holds the request until the bus grants it, then waits for the response strobe. On a clean response it returns read data, shifted down from the addressed byte lane and cut to the access size. It also reports the next address for the register file to store. Size and alignment are checked in every cycle the engine is busy, so a bad combination seen during a transaction aborts it. A 3-bit error code is kept until the debugger clears it.

Top module: `sba_engine`

## Requirements
- R1: During reset and after it, busy_o, req_o, rdata_vld_o and addr_upd_o are 0, and err_o is 0 (no error).
- R2: When idle, an address write strobe with rd_on_addr_i set starts a read: req_o with we_o=0 and baddr_o=addr_i. Without rd_on_addr_i the strobe starts nothing. If an address write strobe with rd_on_addr_i set and a data write strobe arrive in the same cycle, the read is started.
- R3: When idle, a data write strobe starts a write: req_o with we_o=1.
- R4: When idle, a data read strobe starts a read only if rd_on_data_i is set. Otherwise busy_o stays 0.
- R5: busy_o is 1 from the cycle after the start strobe until the cycle after the response. req_o stays high until gnt_i and then drops while the engine waits for rvalid_i.
- R6: On a clean read response, rdata_vld_o is 1 for that cycle. rdata_o is rdata_i shifted right by 8 times the address low bits, with only the lowest 2^size bytes kept.
- R7: The size code s selects 2^s bytes (0=1, 1=2, 2=4, 3=8). be_o has 2^s ones starting at bit addr_i[IW-1:0], and wdata_o is data_i shifted left by 8 times those address bits.
- R8: While busy, a size code above log2(DW/8) aborts to idle and sets error code 4. No request is raised.
- R9: While busy, a legal size with any nonzero address bit below 2^size aborts to idle with error code 2. This includes a change of addr_i during the wait for a response. A size error takes precedence over an alignment error.
- R10: A response with oerr_i sets code 7. Otherwise a response with berr_i sets code 3. Either case suppresses rdata_vld_o and addr_upd_o.
- R11: On a clean response addr_upd_o is 1 for that cycle, and next_addr_o = addr_i + 2^size when auto_inc_i is set, or addr_i when it is clear.
- R12: A nonzero err_o holds its first code against later errors until err_clr_i. A new error in the same cycle as err_clr_i is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | Current address register value |
| data_i | input | DW | Write data register value |
| addr_wr_i | input | 1 | Address register was written |
| data_wr_i | input | 1 | Data register was written |
| data_rd_i | input | 1 | Data register was read |
| rd_on_addr_i | input | 1 | Start a read on address write |
| rd_on_data_i | input | 1 | Start a read on data read |
| auto_inc_i | input | 1 | Advance address after access |
| size_i | input | 3 | Access size code |
| err_clr_i | input | 1 | Clear the stored error code |
| busy_o | output | 1 | Engine not idle |
| rdata_o | output | DW | Aligned read data |
| rdata_vld_o | output | 1 | Read data valid strobe |
| next_addr_o | output | AW | Address to store after access |
| addr_upd_o | output | 1 | Store next_addr_o |
| err_o | output | 3 | Sticky error code |
| req_o | output | 1 | Bus request |
| we_o | output | 1 | Bus write enable |
| baddr_o | output | AW | Bus byte address |
| wdata_o | output | DW | Bus write data, lane placed |
| be_o | output | DW/8 | Bus byte enables |
| gnt_i | input | 1 | Bus grant |
| rvalid_i | input | 1 | Bus response valid |
| rdata_i | input | DW | Bus read data |
| berr_i | input | 1 | Bus error on response |
| oerr_i | input | 1 | Other error on response |

## Verification
Two pairs of functions can meet in one cycle. The error capture can meet the debugger's clear: the bench raises err_clr_i in the very cycle a size error is detected, and it expects the new code 4 rather than 0. The start decode can see an address write with read-on-address and a data write together, and it must choose the read (we_o=0). A third case puts an alignment check against an open transaction. addr_i is made misaligned while the engine waits for a response, and the bench expects an abort with code 2 one edge later.

// File: rtl/sba_pkg.sv
package sba_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD      = 3'd1,
    ST_WR      = 3'd2,
    ST_RD_WAIT = 3'd3,
    ST_WR_WAIT = 3'd4
  } sba_state_e;

  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_ALIGN = 3'd2;
  localparam logic [2:0] ERR_BUS   = 3'd3;
  localparam logic [2:0] ERR_SIZE  = 3'd4;
  localparam logic [2:0] ERR_OTHER = 3'd7;

endpackage

// File: rtl/sba_lanes.sv
module sba_lanes #(
  parameter int DW = 32,
  localparam int BW = DW / 8,
  localparam int IW = $clog2(BW)
) (
  input  logic [IW-1:0] addr_lo_i,
  input  logic [2:0]    size_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic [BW-1:0] be_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic [DW-1:0] rdata_o
);

  logic [31:0]   span;
  logic [31:0]   off;
  logic [IW+2:0] bit_shift;
  logic [DW-1:0] rd_shifted;

  assign span       = 32'd1 << size_i;
  assign off        = 32'(addr_lo_i);
  assign bit_shift  = {addr_lo_i, 3'b000};
  assign bus_wdata_o = wdata_i << bit_shift;
  assign rd_shifted  = bus_rdata_i >> bit_shift;

  for (genvar g = 0; g < BW; g++) begin : g_lane
    assign be_o[g] = (32'(g) >= off) && (32'(g) < off + span);
    assign rdata_o[8*g +: 8] = (32'(g) < span) ? rd_shifted[8*g +: 8] : 8'h00;
  end

endmodule

// File: rtl/sba_addr_step.sv
module sba_addr_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    size_i,
  input  logic          en_i,
  output logic [AW-1:0] next_o
);

  logic [AW-1:0] step;

  assign step   = en_i ? (AW'(1) << size_i) : '0;
  assign next_o = addr_i + step;

endmodule

// File: rtl/sba_engine.sv
module sba_engine
  import sba_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int BW = DW / 8,
  localparam int IW = $clog2(BW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          addr_wr_i,
  input  logic          data_wr_i,
  input  logic          data_rd_i,
  input  logic          rd_on_addr_i,
  input  logic          rd_on_data_i,
  input  logic          auto_inc_i,
  input  logic [2:0]    size_i,
  input  logic          err_clr_i,
  output logic          busy_o,
  output logic [DW-1:0] rdata_o,
  output logic          rdata_vld_o,
  output logic [AW-1:0] next_addr_o,
  output logic          addr_upd_o,
  output logic [2:0]    err_o,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] baddr_o,
  output logic [DW-1:0] wdata_o,
  output logic [BW-1:0] be_o,
  input  logic          gnt_i,
  input  logic          rvalid_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          berr_i,
  input  logic          oerr_i
);

  sba_state_e    state_q, state_d;
  logic [2:0]    err_q, err_d;
  logic [2:0]    fault_code;
  logic          fault;
  logic          active;
  logic          waiting;
  logic          size_bad;
  logic          misalign;
  logic [AW-1:0] low_mask;

  sba_lanes #(.DW(DW)) u_lanes (
    .addr_lo_i   (addr_i[IW-1:0]),
    .size_i      (size_i),
    .wdata_i     (data_i),
    .bus_rdata_i (rdata_i),
    .be_o        (be_o),
    .bus_wdata_o (wdata_o),
    .rdata_o     (rdata_o)
  );

  sba_addr_step #(.AW(AW)) u_step (
    .addr_i (addr_i),
    .size_i (size_i),
    .en_i   (auto_inc_i),
    .next_o (next_addr_o)
  );

  // checks on the access shape, valid in every non-idle cycle
  assign active   = (state_q != ST_IDLE);
  assign waiting  = (state_q == ST_RD_WAIT) || (state_q == ST_WR_WAIT);
  assign size_bad = (32'(size_i) > 32'(IW));
  assign low_mask = ~({AW{1'b1}} << size_i);
  assign misalign = |(addr_i & low_mask);

  always_comb begin
    fault_code = ERR_NONE;
    if (active && size_bad) begin
      fault_code = ERR_SIZE;
    end else if (active && misalign) begin
      fault_code = ERR_ALIGN;
    end else if (waiting && rvalid_i) begin
      if (oerr_i)      fault_code = ERR_OTHER;
      else if (berr_i) fault_code = ERR_BUS;
    end
  end
  assign fault = (fault_code != ERR_NONE);

  // next-state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (addr_wr_i && rd_on_addr_i)      state_d = ST_RD;
        else if (data_wr_i)                 state_d = ST_WR;
        else if (data_rd_i && rd_on_data_i) state_d = ST_RD;
      end
      ST_RD:      if (gnt_i)    state_d = ST_RD_WAIT;
      ST_WR:      if (gnt_i)    state_d = ST_WR_WAIT;
      ST_RD_WAIT: if (rvalid_i) state_d = ST_IDLE;
      ST_WR_WAIT: if (rvalid_i) state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
    if (fault) state_d = ST_IDLE;
  end

  // sticky error: first code kept, a new fault beats a clear
  always_comb begin
    err_d = err_q;
    if (fault && ((err_q == ERR_NONE) || err_clr_i)) err_d = fault_code;
    else if (err_clr_i)                              err_d = ERR_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= ERR_NONE;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  assign busy_o      = active;
  assign err_o       = err_q;
  assign req_o       = ((state_q == ST_RD) || (state_q == ST_WR)) && !fault;
  assign we_o        = (state_q == ST_WR) || (state_q == ST_WR_WAIT);
  assign baddr_o     = addr_i;
  assign rdata_vld_o = (state_q == ST_RD_WAIT) && rvalid_i && !fault;
  assign addr_upd_o  = waiting && rvalid_i && !fault;

  // R5: request held until granted unless aborted
  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i) |=> (req_o || fault));

  // R5: grant moves to the response wait with request dropped
  assert_grant_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && gnt_i) |=> (busy_o && !req_o));

  // R6: read data returned ends the transaction
  assert_rvld_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_vld_o |=> !busy_o);

  // R7: enabled lane count equals the access width
  assert_be_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ($countones(be_o) == (32'd1 << size_i)));

  // R8: illegal size aborts and leaves an error recorded
  assert_size_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && size_bad) |=> (!busy_o && (err_o != ERR_NONE)));

  // R9: misalignment aborts
  assert_align_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !size_bad && misalign) |=> !busy_o);

  // R12: stored code holds until cleared
  assert_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((err_o != ERR_NONE) && !err_clr_i) |=> $stable(err_o));

endmodule

// File: tb/sba_engine_tb.sv
`timescale 1ns/1ps
module sba_engine_tb;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] WDAT = 32'h5566_7788;
  localparam logic [31:0] RPAT = 32'hA1B2_C3D4;

  // fields: kind[31:28] (0 rd-on-addr,1 write,2 rd-on-data) size[27:24]
  // addr low byte[23:16] auto[15:12] grant delay[11:8] resp[7:4] (b0 bus, b1 other) exp err[3:0]
  localparam int NV = 14;
  localparam logic [31:0] VEC [NV] = '{
    32'h0210_1000, 32'h0013_1100, 32'h0112_0000, 32'h1220_1200,
    32'h1021_1000, 32'h1122_0000, 32'h2230_1000, 32'h0240_0013,
    32'h0244_0037, 32'h1248_0027, 32'h0151_0002, 32'h1350_0004,
    32'h0351_0004, 32'h2063_1013
  };

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] data_i;
  logic addr_wr_i, data_wr_i, data_rd_i, rd_on_addr_i, rd_on_data_i, auto_inc_i;
  logic [2:0]    size_i;
  logic          err_clr_i;
  logic          busy_o, rdata_vld_o, addr_upd_o, req_o, we_o;
  logic [DW-1:0] rdata_o, wdata_o;
  logic [AW-1:0] next_addr_o, baddr_o;
  logic [2:0]    err_o;
  logic [3:0]    be_o;
  logic          gnt_i, rvalid_i, berr_i, oerr_i;
  logic [DW-1:0] rdata_i;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  sba_engine #(.AW(AW), .DW(DW)) u_dut (
    .clk_i, .rst_ni, .addr_i, .data_i, .addr_wr_i, .data_wr_i, .data_rd_i,
    .rd_on_addr_i, .rd_on_data_i, .auto_inc_i, .size_i, .err_clr_i,
    .busy_o, .rdata_o, .rdata_vld_o, .next_addr_o, .addr_upd_o, .err_o,
    .req_o, .we_o, .baddr_o, .wdata_o, .be_o,
    .gnt_i, .rvalid_i, .rdata_i, .berr_i, .oerr_i
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_err();
    @(negedge clk_i); err_clr_i = 1'b1;
    @(negedge clk_i); err_clr_i = 1'b0;
  endtask

  task automatic idle_inputs();
    addr_wr_i = 0; data_wr_i = 0; data_rd_i = 0;
    gnt_i = 0; rvalid_i = 0; berr_i = 0; oerr_i = 0;
  endtask

  // grant at once, then clean response
  task automatic finish_txn();
    gnt_i = 1'b1;
    @(negedge clk_i); gnt_i = 1'b0; rvalid_i = 1'b1; rdata_i = RPAT;
    @(negedge clk_i); rvalid_i = 1'b0;
  endtask

  task automatic run_vec(input logic [31:0] v);
    logic [3:0]  kind = v[31:28];
    logic [2:0]  sz   = v[26:24];
    logic [7:0]  alo  = v[23:16];
    logic        au   = v[12];
    logic [3:0]  gd   = v[11:8];
    logic [1:0]  rsp  = v[5:4];
    logic [2:0]  eerr = v[2:0];
    logic [1:0]  off  = alo[1:0];
    logic [63:0] mask = (64'd1 << (8 * (1 << sz))) - 64'd1;
    logic [31:0] exp_rd  = (RPAT >> (8 * off)) & mask[31:0];
    logic [3:0]  exp_be  = 4'(((1 << (1 << sz)) - 1) << off);
    logic [31:0] exp_wd  = WDAT << (8 * off);
    logic [31:0] adr     = BASE | 32'(alo);
    logic [31:0] exp_nx  = adr + (au ? (32'd1 << sz) : 32'd0);
    clear_err();
    @(negedge clk_i);
    addr_i = adr; size_i = sz; auto_inc_i = au; data_i = WDAT;
    rd_on_addr_i = (kind == 0); rd_on_data_i = (kind == 2);
    addr_wr_i = (kind == 0); data_wr_i = (kind == 1); data_rd_i = (kind == 2);
    @(negedge clk_i);
    addr_wr_i = 0; data_wr_i = 0; data_rd_i = 0;
    #1;
    if (eerr == 3'd2 || eerr == 3'd4) begin
      chk(busy_o && !req_o, "R8/R9 no request on bad access", {busy_o, req_o}, 2'b10);
      @(negedge clk_i); #1;
      chk(!busy_o, "R8/R9 abort to idle", busy_o, 0);
      chk(err_o == eerr, (eerr == 3'd4) ? "R8 size code" : "R9 align code", err_o, eerr);
      return;
    end
    for (int i = 0; i < gd; i++) begin
      chk(req_o, "R5 request held before grant", req_o, 1);
      @(negedge clk_i); #1;
    end
    gnt_i = 1'b1; #1;
    chk(req_o && busy_o, "R5 request at grant", req_o, 1);
    chk(we_o == (kind == 1), (kind == 1) ? "R3 write direction" : "R2/R4 read direction", we_o, kind == 1);
    chk(baddr_o == adr, "R2 bus address", baddr_o, adr);
    chk(be_o == exp_be, "R7 byte enables", be_o, exp_be);
    if (kind == 1) chk(wdata_o == exp_wd, "R7 write lane", wdata_o, exp_wd);
    @(negedge clk_i); gnt_i = 1'b0; #1;
    chk(!req_o && busy_o, "R5 waiting for response", {busy_o, req_o}, 2'b10);
    rvalid_i = 1'b1; rdata_i = RPAT; berr_i = rsp[0]; oerr_i = rsp[1]; #1;
    if (eerr == 0) begin
      chk(rdata_vld_o == (kind != 1), "R6 read valid strobe", rdata_vld_o, kind != 1);
      if (kind != 1) chk(rdata_o == exp_rd, "R6 read data alignment", rdata_o, exp_rd);
      chk(addr_upd_o, "R11 address update strobe", addr_upd_o, 1);
      chk(next_addr_o == exp_nx, "R11 next address", next_addr_o, exp_nx);
    end else begin
      chk(!rdata_vld_o && !addr_upd_o, "R10 error suppresses results", {rdata_vld_o, addr_upd_o}, 0);
    end
    @(negedge clk_i); rvalid_i = 0; berr_i = 0; oerr_i = 0; #1;
    chk(!busy_o, "R5 idle after response", busy_o, 0);
    chk(err_o == eerr, "R10 response error code", err_o, eerr);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired act=%h exp=%h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    addr_i = BASE; data_i = '0; size_i = 3'd2; auto_inc_i = 0;
    rd_on_addr_i = 0; rd_on_data_i = 0; err_clr_i = 0; rdata_i = '0;
    idle_inputs();
    repeat (3) @(negedge clk_i);
    #1;
    chk(!busy_o && !req_o && !rdata_vld_o && !addr_upd_o, "R1 outputs in reset",
        {busy_o, req_o, rdata_vld_o, addr_upd_o}, 0);
    chk(err_o == 0, "R1 error code in reset", err_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(!busy_o && err_o == 0, "R1 idle after reset", {busy_o, err_o}, 0);

    for (int n = 0; n < NV; n++) run_vec(VEC[n]);

    // R2: address write without read-on-address starts nothing
    @(negedge clk_i);
    addr_i = BASE; size_i = 3'd2; rd_on_addr_i = 0; addr_wr_i = 1;
    @(negedge clk_i); addr_wr_i = 0; #1;
    chk(!busy_o && !req_o, "R2 no read without flag", busy_o, 0);

    // R4: data read without read-on-data starts nothing
    rd_on_data_i = 0; data_rd_i = 1;
    @(negedge clk_i); data_rd_i = 0; #1;
    chk(!busy_o, "R4 no read without flag", busy_o, 0);

    // R2: address-triggered read wins over a simultaneous data write
    rd_on_addr_i = 1; addr_wr_i = 1; data_wr_i = 1;
    @(negedge clk_i); addr_wr_i = 0; data_wr_i = 0; #1;
    chk(req_o && !we_o, "R2 read wins over write", {req_o, we_o}, 2'b10);
    finish_txn(); #1;
    chk(!busy_o, "R5 idle after collision txn", busy_o, 0);

    // R9: misalignment appearing during the response wait aborts
    clear_err();
    addr_i = BASE | 32'h100; size_i = 3'd2; addr_wr_i = 1;
    @(negedge clk_i); addr_wr_i = 0; gnt_i = 1;
    @(negedge clk_i); gnt_i = 0; addr_i = BASE | 32'h102; #1;
    chk(busy_o, "R9 still waiting before abort", busy_o, 1);
    @(negedge clk_i); #1;
    chk(!busy_o && err_o == 3'd2, "R9 abort in flight", {busy_o, err_o}, 4'h2);

    // R12: later size error does not overwrite stored code 2
    addr_i = BASE; size_i = 3'd3; data_wr_i = 1;
    @(negedge clk_i); data_wr_i = 0;
    @(negedge clk_i); #1;
    chk(!busy_o && err_o == 3'd2, "R12 first code kept", err_o, 2);

    // R12: clear in the same cycle as a new size error stores the new code
    addr_wr_i = 1;
    @(negedge clk_i); addr_wr_i = 0; err_clr_i = 1;
    @(negedge clk_i); err_clr_i = 0; #1;
    chk(err_o == 3'd4, "R12 new error beats clear", err_o, 4);
    clear_err(); #1;
    chk(err_o == 3'd0, "R12 clear alone", err_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule